// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Byte Register Window

This block keeps calendar time from seconds up to a two-digit year. Every time field is held in packed BCD. A synchronous byte bus reaches eight registers: one control byte and seven time bytes. Counting runs from a tick-enable input. A prescaler parameter sets how many tick pulses make one second, so the input may be a 1 Hz strobe or a faster enable.

Software freezes a coherent picture of the time with a read-hold bit. To set the clock, software raises a staging bit. This copies the running time into a shadow set. The fields it writes go only to that shadow set, and dropping the bit moves the whole set into the counters in one cycle. A stop flag in the seconds byte halts timekeeping. A kick flag, a test flag and a signed calibration value are stored and read back for the analog parts that live outside this block.

Top module: `rtc_bcd_core`

## Requirements
- R1: After reset the registers read as follows: control 0x00, seconds 0x00, minutes 0x00, hours 0x00, weekday 0x01, date 0x01, month 0x01 and year 0x00.
- R2: Register index 0 is control, and it reads {stage, hold, sign, magnitude[4:0]}. Indices 1 to 7 are seconds, minutes, hours, weekday, date, month and year. Time fields are BCD, and unused high bits read 0.
- R3: With stop clear, seconds advance by one on every DIV-th tick pulse.
- R4: Seconds and minutes wrap from 59 to 00 with a carry. Hours wrap from 23 to 00 and advance both the weekday (7 wraps to 1) and the date.
- R5: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months except 02. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: February ends on 29 when the BCD year is a multiple of four, and on 28 otherwise.
- R7: Seconds bit 7 is the stop flag. While it is set, no field changes. Clearing it resumes counting from the held value.
- R8: While control bit 6 (hold) is set, the time bytes read back the value frozen when the bit was set, and the counters keep running. Clearing hold shows the live time at once.
- R9: Setting control bit 7 (stage) copies the live time into the shadow set. While stage is set, writes to time bytes go only to the shadow set. While stage is clear, the time field of a write is ignored.
- R10: When stage goes from 1 to 0, every shadow field loads into the counters in that cycle and the prescaler restarts, so the next second needs a full DIV ticks.
- R11: Hours bit 7 (kick), weekday bit 6 (test), the stop flag and the calibration bits are written directly on any write to their byte. They read back unchanged, and only stop affects counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Timebase pulse, one per prescaler step |
| bus_addr | input | 3 | Register index |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |

## Verification
The hardest cases to reach from the ports are the month-end and year-end carries. Counting there from reset would take millions of ticks. The stimulus instead stages a time of 23:59:59 on the last day of the chosen month, releases the stage bit, and supplies DIV tick pulses. February is run in both a leap year and a plain year, and December 99 is run to cover the wrap to year 00. The first of those ticks also shows that the prescaler restarted on the load.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    typedef struct packed {
        logic [6:0] sec;
        logic [6:0] min;
        logic [5:0] hour;
        logic [2:0] dow;
        logic [5:0] date;
        logic [4:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    typedef enum logic [2:0] {
        RIDX_CTRL = 3'd0,
        RIDX_SEC  = 3'd1,
        RIDX_MIN  = 3'd2,
        RIDX_HOUR = 3'd3,
        RIDX_DOW  = 3'd4,
        RIDX_DATE = 3'd5,
        RIDX_MON  = 3'd6,
        RIDX_YEAR = 3'd7
    } rtc_idx_e;

    localparam rtc_time_t TIME_AT_RESET = '{
        sec: 7'h00, min: 7'h00, hour: 6'h00, dow: 3'd1,
        date: 6'h01, mon: 5'h01, year: 8'h00
    };

    // Two-digit BCD increment (no wrap handling beyond the digit carry).
    function automatic logic [7:0] bcd_next(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        else                return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Multiple of four in decimal: odd tens need ones 2/6, even tens need 0/4/8.
    function automatic logic leap_bcd(input logic [7:0] y);
        if (y[4]) return (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
        else      return (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    endfunction

    function automatic logic [5:0] month_end(input logic [4:0] m, input logic [7:0] y);
        case (m)
            5'h02:                      return leap_bcd(y) ? 6'h29 : 6'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 6'h30;
            default:                    return 6'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_chain.sv
`timescale 1ns/1ps
module rtc_chain
    import rtc_pkg::*;
#(
    parameter int DIV = 1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      halt,
    input  logic      load,
    input  rtc_time_t load_val,
    output rtc_time_t now_q
);
    localparam int SUB_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic      step;
    rtc_time_t nxt;

    generate
        if (DIV == 1) begin : g_nodiv
            assign step = tick & ~halt;
        end else begin : g_div
            logic [SUB_W-1:0] sub_q;
            always_ff @(posedge clk) begin
                if (rst || load)
                    sub_q <= '0;
                else if (tick && !halt)
                    sub_q <= (sub_q == SUB_W'(DIV - 1)) ? '0 : sub_q + 1'b1;
            end
            assign step = tick & ~halt & (sub_q == SUB_W'(DIV - 1));

            // R3
            sub_range_chk: assert property (@(posedge clk) disable iff (rst)
                sub_q <= SUB_W'(DIV - 1));
        end
    endgenerate

    // Carry cascade: each field moves only when every lower field wraps.
    always_comb begin
        nxt = now_q;
        if (load) begin
            nxt = load_val;
        end else if (step) begin
            if (now_q.sec != 7'h59) begin
                nxt.sec = 7'(bcd_next({1'b0, now_q.sec}));
            end else begin
                nxt.sec = 7'h00;
                if (now_q.min != 7'h59) begin
                    nxt.min = 7'(bcd_next({1'b0, now_q.min}));
                end else begin
                    nxt.min = 7'h00;
                    if (now_q.hour != 6'h23) begin
                        nxt.hour = 6'(bcd_next({2'b00, now_q.hour}));
                    end else begin
                        nxt.hour = 6'h00;
                        nxt.dow  = (now_q.dow >= 3'd7) ? 3'd1 : now_q.dow + 3'd1;
                        if (now_q.date < month_end(now_q.mon, now_q.year)) begin
                            nxt.date = 6'(bcd_next({2'b00, now_q.date}));
                        end else begin
                            nxt.date = 6'h01;
                            if (now_q.mon < 5'h12) begin
                                nxt.mon = 5'(bcd_next({3'b000, now_q.mon}));
                            end else begin
                                nxt.mon  = 5'h01;
                                nxt.year = (now_q.year == 8'h99) ? 8'h00 : bcd_next(now_q.year);
                            end
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) now_q <= TIME_AT_RESET;
        else     now_q <= nxt;
    end

    // R7
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (halt && !load) |=> $stable(now_q));

    // R10
    load_apply_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (now_q == $past(load_val)));

    // R4
    sec_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && now_q.sec == 7'h59) |=> (now_q.sec == 7'h00));

endmodule

// File: rtl/rtc_regfile.sv
`timescale 1ns/1ps
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    input  rtc_time_t  live,
    output logic [7:0] bus_rdata,
    output logic       load,
    output rtc_time_t  load_val,
    output logic       halt
);
    logic       stage_q, hold_q, sign_q;
    logic [4:0] mag_q;
    logic       stop_q, kick_q, ftest_q;
    rtc_time_t  shadow_q, snap_q, vis;

    rtc_idx_e idx;
    logic     ctrl_wr, stage_on;

    assign idx      = rtc_idx_e'(bus_addr);
    assign ctrl_wr  = bus_we && (idx == RIDX_CTRL);
    assign stage_on = ctrl_wr &&  bus_wdata[7] && !stage_q;
    assign load     = ctrl_wr && !bus_wdata[7] &&  stage_q;
    assign load_val = shadow_q;
    assign halt     = stop_q;
    assign vis      = hold_q ? snap_q : live;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= 1'b0;
            hold_q  <= 1'b0;
            sign_q  <= 1'b0;
            mag_q   <= '0;
            stop_q  <= 1'b0;
            kick_q  <= 1'b0;
            ftest_q <= 1'b0;
        end else if (bus_we) begin
            case (idx)
                RIDX_CTRL: {stage_q, hold_q, sign_q, mag_q} <= bus_wdata;
                RIDX_SEC:  stop_q  <= bus_wdata[7];
                RIDX_HOUR: kick_q  <= bus_wdata[7];
                RIDX_DOW:  ftest_q <= bus_wdata[6];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= TIME_AT_RESET;
        end else if (stage_on) begin
            shadow_q <= live;
        end else if (bus_we && stage_q) begin
            case (idx)
                RIDX_SEC:  shadow_q.sec  <= bus_wdata[6:0];
                RIDX_MIN:  shadow_q.min  <= bus_wdata[6:0];
                RIDX_HOUR: shadow_q.hour <= bus_wdata[5:0];
                RIDX_DOW:  shadow_q.dow  <= bus_wdata[2:0];
                RIDX_DATE: shadow_q.date <= bus_wdata[5:0];
                RIDX_MON:  shadow_q.mon  <= bus_wdata[4:0];
                RIDX_YEAR: shadow_q.year <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          snap_q <= TIME_AT_RESET;
        else if (!hold_q) snap_q <= live;
    end

    always_comb begin
        case (idx)
            RIDX_CTRL: bus_rdata = {stage_q, hold_q, sign_q, mag_q};
            RIDX_SEC:  bus_rdata = {stop_q, vis.sec};
            RIDX_MIN:  bus_rdata = {1'b0, vis.min};
            RIDX_HOUR: bus_rdata = {kick_q, 1'b0, vis.hour};
            RIDX_DOW:  bus_rdata = {1'b0, ftest_q, 3'b000, vis.dow};
            RIDX_DATE: bus_rdata = {2'b00, vis.date};
            RIDX_MON:  bus_rdata = {3'b000, vis.mon};
            default:   bus_rdata = vis.year;
        endcase
    end

    // R8
    freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q && $past(hold_q)) |-> $stable(snap_q));

    // R9
    stage_copy_chk: assert property (@(posedge clk) disable iff (rst)
        stage_on |=> (shadow_q == $past(live)));

endmodule

// File: rtl/rtc_bcd_core.sv
`timescale 1ns/1ps
module rtc_bcd_core
    import rtc_pkg::*;
#(
    parameter int DIV = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic [2:0] bus_addr,
    input  logic       bus_we,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata
);
    rtc_time_t live_time, staged_time;
    logic      do_load, do_halt;

    rtc_chain #(.DIV(DIV)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick_en),
        .halt     (do_halt),
        .load     (do_load),
        .load_val (staged_time),
        .now_q    (live_time)
    );

    rtc_regfile u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .live      (live_time),
        .bus_rdata (bus_rdata),
        .load      (do_load),
        .load_val  (staged_time),
        .halt      (do_halt)
    );

    // R10
    load_clear_chk: assert property (@(posedge clk) disable iff (rst)
        do_load |=> (bus_rdata[7] == 1'b0 || bus_addr != 3'd0));

endmodule

// File: tb/rtc_bcd_core_test.sv
`timescale 1ns/1ps
module rtc_bcd_core_test;
    localparam int DIV = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic [2:0] bus_addr = 3'd0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    rtc_bcd_core #(.DIV(DIV)) uut (
        .clk(clk), .rst(rst), .tick_en(tick_en),
        .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // Monitor: pops one expectation and compares away from the clock edge.
    initial begin
        forever begin
            sb_item_t it;
            wait (sb_q.size() != 0);
            #1;
            it = sb_q.pop_front();
            n_cmp++;
            if (bus_rdata !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got %02h expected %02h", it.tag, bus_rdata, it.exp);
            end
        end
    end

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        sb_item_t it;
        @(negedge clk);
        bus_addr = a;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_we    = 1'b1;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_en = 1'b1;
            @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic stage_eod(input logic [7:0] d, input logic [7:0] m, input logic [7:0] y);
        wr(3'd0, 8'h80);
        wr(3'd1, 8'h59); wr(3'd2, 8'h59); wr(3'd3, 8'h23);
        wr(3'd5, d); wr(3'd6, m); wr(3'd7, y);
        wr(3'd0, 8'h00);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset values
        expect_reg(3'd0, 8'h00, "R1 ctrl");
        expect_reg(3'd1, 8'h00, "R1 sec");
        expect_reg(3'd2, 8'h00, "R1 min");
        expect_reg(3'd3, 8'h00, "R1 hour");
        expect_reg(3'd4, 8'h01, "R1 dow");
        expect_reg(3'd5, 8'h01, "R1 date");
        expect_reg(3'd6, 8'h01, "R1 month");
        expect_reg(3'd7, 8'h00, "R1 year");

        // R9 staging: writes do not reach the visible time before release
        wr(3'd0, 8'h80);
        expect_reg(3'd0, 8'h80, "R2 ctrl stage bit");
        wr(3'd1, 8'h58); wr(3'd2, 8'h59); wr(3'd3, 8'h23); wr(3'd4, 8'h07);
        wr(3'd5, 8'h28); wr(3'd6, 8'h02); wr(3'd7, 8'h99);
        expect_reg(3'd1, 8'h00, "R9 staged sec hidden");
        wr(3'd0, 8'h00);
        expect_reg(3'd1, 8'h58, "R10 load sec");
        expect_reg(3'd6, 8'h02, "R10 load month");
        ticks(1);
        expect_reg(3'd1, 8'h58, "R10 prescaler restarted");
        ticks(1);
        expect_reg(3'd1, 8'h59, "R3 second step");
        ticks(2);
        // R4, R5, R6: 99 is not a leap year, Feb 28 -> Mar 01
        expect_reg(3'd1, 8'h00, "R4 sec wrap");
        expect_reg(3'd2, 8'h00, "R4 min wrap");
        expect_reg(3'd3, 8'h00, "R4 hour wrap");
        expect_reg(3'd4, 8'h01, "R4 dow 7->1");
        expect_reg(3'd5, 8'h01, "R6 plain Feb end");
        expect_reg(3'd6, 8'h03, "R6 plain Feb month");
        expect_reg(3'd7, 8'h99, "R5 year held");

        // R6 leap year 96: Feb 28 -> Feb 29 -> Mar 01
        stage_eod(8'h28, 8'h02, 8'h96);
        ticks(2);
        expect_reg(3'd5, 8'h29, "R6 leap Feb 29");
        expect_reg(3'd6, 8'h02, "R6 leap month held");
        expect_reg(3'd4, 8'h02, "R4 dow advance");
        stage_eod(8'h29, 8'h02, 8'h96);
        ticks(2);
        expect_reg(3'd5, 8'h01, "R6 leap Feb end");
        expect_reg(3'd6, 8'h03, "R6 leap to March");

        // R5 30-day month and year end
        stage_eod(8'h30, 8'h04, 8'h96);
        ticks(2);
        expect_reg(3'd5, 8'h01, "R5 April end");
        expect_reg(3'd6, 8'h05, "R5 to May");
        stage_eod(8'h31, 8'h12, 8'h99);
        ticks(2);
        expect_reg(3'd5, 8'h01, "R5 Dec end date");
        expect_reg(3'd6, 8'h01, "R5 Dec end month");
        expect_reg(3'd7, 8'h00, "R5 year 99->00");
        expect_reg(3'd4, 8'h05, "R4 dow after year end");

        // R9 time write ignored without stage
        wr(3'd2, 8'h33);
        expect_reg(3'd2, 8'h00, "R9 unstaged write ignored");

        // R7 stop flag
        wr(3'd1, 8'h80);
        expect_reg(3'd1, 8'h80, "R7 stop set");
        ticks(4);
        expect_reg(3'd1, 8'h80, "R7 stopped");
        wr(3'd1, 8'h00);
        ticks(2);
        expect_reg(3'd1, 8'h01, "R7 resumed");

        // R8 read hold
        wr(3'd0, 8'h40);
        ticks(2);
        expect_reg(3'd1, 8'h01, "R8 frozen view");
        wr(3'd0, 8'h00);
        expect_reg(3'd1, 8'h02, "R8 live on release");

        // R11 flags and calibration
        wr(3'd3, 8'h80);
        expect_reg(3'd3, 8'h80, "R11 kick readback");
        wr(3'd4, 8'h40);
        expect_reg(3'd4, 8'h45, "R11 test flag readback");
        wr(3'd0, 8'h25);
        expect_reg(3'd0, 8'h25, "R11 calibration readback");
        ticks(2);
        expect_reg(3'd1, 8'h03, "R11 flags do not stop count");
        expect_reg(3'd3, 8'h80, "R11 kick kept");

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule